// File: doc/BRIEF.md
# Minimum Transition Spacing Enforcer

This block sits after a fast flash angle core. The core produces single-step transition events, each tagged as up or down. Under noise, neighbouring comparator levels can fire in very quick succession. The block forwards these events so that no two released steps are closer together than a programmable number of clock cycles.

An event that arrives while the spacing window is already open leaves after one register stage. An event that arrives early waits in a small in-order queue. It is released on the exact cycle the window opens. No event is dropped unless the queue overflows.

The gap comes either from an external cycle count or from a built-in default setting that acts as a tie-off. Any spacing seen further downstream is this gap multiplied by that stage's own division factor.

Top module: `step_spacer`

## Requirements
- R1: While `rst_n` is low at a clock edge, and in the cycle after that edge, `step_out` and `ovf_err` are 0.
- R2: The first event accepted after reset leaves on `step_out` in the very next cycle, whatever was released before the reset.
- R3: An event whose input cycle comes at least one effective gap after the previous release, with the queue empty, appears on `step_out` exactly one cycle after it was presented, with `dir_out` equal to its `dir_in`.
- R4: Two consecutive `step_out` pulses are never closer than the effective gap in cycles. An early event is released on the first cycle that satisfies this.
- R5: Waiting events leave in arrival order and keep their direction (1 = up, 0 = down). Up and down events that wait together are both released and never cancel.
- R6: An effective gap of 0 or 1 allows a `step_out` pulse on every clock.
- R7: At most 4 events wait. An event that arrives while 4 are waiting and none leaves is discarded, and `ovf_err` goes to 1 and stays there until reset.
- R8: With `gap_ext_en` low, the effective gap is the parameter `DEFAULT_GAP` (4 cycles, 32 ns at 125 MHz) and `gap_cycles` has no effect. With `gap_ext_en` high, the effective gap is `gap_cycles`.
- R9: Reset discards all waiting events; none of them appears on `step_out` afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_in | input | 1 | Transition event strobe, one cycle per event |
| dir_in | input | 1 | Direction of the event on `step_in` (1 = up) |
| gap_ext_en | input | 1 | 1 selects `gap_cycles`, 0 selects the built-in default gap |
| gap_cycles | input | 10 | Minimum spacing between released events, in cycles |
| step_out | output | 1 | Spaced event strobe |
| dir_out | output | 1 | Direction of the event on `step_out` |
| ovf_err | output | 1 | Sticky flag: an event was discarded because the queue was full |

## Verification
The bench builds the block with its defaults: a 10-bit gap, a 4-entry queue and a default gap of 4. The 4-entry queue makes overflow reachable with six back-to-back events under a 20-cycle gap. The small default gap makes the tie-off spacing visible within a few cycles. External gaps of 0, 1, 5, 20 and 30 cover the following:
- the every-cycle limit;
- the exact boundary, where an event lands on the opening cycle or one cycle before it;
- an order-preserving release of mixed up and down bursts;
- a reset that lands while events are waiting.

// File: rtl/step_spacer_pkg.sv
// Package: shared widths and helpers for the step spacer.
// Assumes gap counts are unsigned cycle numbers.
package step_spacer_pkg;

    localparam int unsigned GAP_W_DEF = 10;

    // Turn a requested gap into the gap actually enforced (0 behaves as 1).
    function automatic logic [GAP_W_DEF-1:0] clamp_gap(input logic [GAP_W_DEF-1:0] g);
        return (g == '0) ? GAP_W_DEF'(1) : g;
    endfunction

endpackage

// File: rtl/gap_timer.sv
// Module: gap_timer
// Counts the cycles since the last release and reports when another
// release may happen. Assumes `fire` is high only in a cycle where `ready`
// was high. After reset the counter saturates at its maximum, so the
// first event passes at once.
module gap_timer
    import step_spacer_pkg::*;
#(
    parameter int unsigned GAP_W = GAP_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [GAP_W-1:0] gap_eff,
    output logic             ready
);
    localparam logic [GAP_W-1:0] SAT = '1;

    logic [GAP_W-1:0] since_q;
    logic [GAP_W-1:0] gap_cl;

    // Enforced gap: a request of zero is treated as one.
    always_comb gap_cl = (gap_eff == '0) ? GAP_W'(1) : gap_eff;

    // Distance counter: restarts at one on a release, otherwise saturates upward.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_q <= SAT;
        else if (fire)            since_q <= GAP_W'(1);
        else if (since_q != SAT)  since_q <= since_q + 1'b1;
    end

    // Release window is open once the distance reaches the gap.
    always_comb ready = (since_q >= gap_cl);

    // R4: a release never happens while the window is closed.
    fire_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> ready);

endmodule

// File: rtl/event_fifo.sv
// Module: event_fifo
// Small in-order queue of direction bits for events that must wait.
// Assumes the caller never pushes when full without a pop in the same cycle,
// and never pops when empty. The pointer wrap is chosen by generate
// according to whether DEPTH is a power of two.
module event_fifo #(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    input  logic din,
    output logic dout,
    output logic empty,
    output logic full
);
    localparam int unsigned PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam bit          POW2  = ((DEPTH & (DEPTH - 1)) == 0);

    logic [DEPTH-1:0] slots_q;
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, wr_nxt, rd_nxt;
    logic [CNT_W-1:0] cnt_q;

    generate
        if (POW2 && (DEPTH > 1)) begin : g_pow2_wrap
            // Natural pointer wrap for power-of-two depths.
            always_comb begin
                wr_nxt = wr_ptr_q + 1'b1;
                rd_nxt = rd_ptr_q + 1'b1;
            end
        end else begin : g_cmp_wrap
            // Explicit pointer wrap for other depths.
            always_comb begin
                wr_nxt = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
                rd_nxt = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
            end
        end
    endgenerate

    // Store the incoming direction bit at the write slot.
    always_ff @(posedge clk) begin
        if (!rst_n)    slots_q <= '0;
        else if (push) slots_q[wr_ptr_q] <= din;
    end

    // Advance the pointers on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (push) wr_ptr_q <= wr_nxt;
            if (pop)  rd_ptr_q <= rd_nxt;
        end
    end

    // Track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else begin
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Head and status outputs.
    always_comb begin
        dout  = slots_q[rd_ptr_q];
        empty = (cnt_q == '0);
        full  = (cnt_q == CNT_W'(DEPTH));
    end

    // R7
    queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push) |-> pop);

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/step_spacer.sv
// Module: step_spacer (top)
// Forwards up/down step events so that released events are spaced at least
// the effective gap apart. Early events wait in order in event_fifo. The
// output is registered, so an on-time event appears one cycle later.
// Assumes step_in is a single-cycle strobe per event and that the gap only
// changes while the block is idle.
module step_spacer
    import step_spacer_pkg::*;
#(
    parameter int unsigned GAP_W       = GAP_W_DEF,
    parameter int unsigned DEPTH       = 4,
    parameter int unsigned DEFAULT_GAP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_in,
    input  logic             dir_in,
    input  logic             gap_ext_en,
    input  logic [GAP_W-1:0] gap_cycles,
    output logic             step_out,
    output logic             dir_out,
    output logic             ovf_err
);
    logic [GAP_W-1:0] gap_eff;
    logic             ready, q_empty, q_full, q_head;
    logic             rel_q, rel_direct, release_now, rel_dir;
    logic             push, drop;

    // Gap source: external count or the built-in default.
    always_comb gap_eff = gap_ext_en ? gap_cycles : GAP_W'(DEFAULT_GAP);

    // Release and queue control: the queue has priority over new arrivals.
    always_comb begin
        rel_q       = ready && !q_empty;
        rel_direct  = ready && q_empty && step_in;
        release_now = rel_q || rel_direct;
        rel_dir     = rel_q ? q_head : dir_in;
        push        = step_in && !rel_direct && (!q_full || rel_q);
        drop        = step_in && !rel_direct && q_full && !rel_q;
    end

    gap_timer #(.GAP_W(GAP_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (release_now),
        .gap_eff (gap_eff),
        .ready   (ready)
    );

    event_fifo #(.DEPTH(DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (rel_q),
        .din   (dir_in),
        .dout  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    // Output stage: register the strobe, and hold the direction between events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_out <= 1'b0;
            dir_out  <= 1'b0;
        end else begin
            step_out <= release_now;
            if (release_now) dir_out <= rel_dir;
        end
    end

    // Sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)    ovf_err <= 1'b0;
        else if (drop) ovf_err <= 1'b1;
    end

    // Output-side spacing monitor for the assertions below.
    logic [GAP_W-1:0] mon_dist;
    logic             mon_seen;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_dist <= '0;
            mon_seen <= 1'b0;
        end else begin
            mon_seen <= mon_seen || step_out;
            if (step_out)              mon_dist <= GAP_W'(1);
            else if (mon_dist != '1)   mon_dist <= mon_dist + 1'b1;
        end
    end

    // R4
    spacing_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_out && mon_seen) |-> (mon_dist >= clamp_gap(gap_eff)));

    // R3
    direct_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && q_empty && step_in) |=> (step_out && dir_out == $past(dir_in)));

    // R5
    queued_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !q_empty) |=> step_out);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

endmodule

// File: tb/step_spacer_tb.sv
module step_spacer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_in = 1'b0, dir_in = 1'b0, gap_ext_en = 1'b1;
    logic [9:0] gap_cycles = 10'd5;
    logic       step_out, dir_out, ovf_err;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int log_cyc [64];
    bit log_dir [64];
    int log_n = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    step_spacer u_dut (
        .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in),
        .gap_ext_en(gap_ext_en), .gap_cycles(gap_cycles),
        .step_out(step_out), .dir_out(dir_out), .ovf_err(ovf_err));

    always @(posedge clk) cyc <= cyc + 1;

    // Record every released event with its cycle.
    always @(negedge clk) begin
        if (step_out && log_n < 64) begin
            log_cyc[log_n] = cyc;
            log_dir[log_n] = dir_out;
            log_n++;
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(bit s, bit d);
        step_in = s; dir_in = d;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0);
    endtask

    task automatic do_reset();
        rst_n = 0; step_in = 0;
        @(negedge clk);
        chk("R1 step_out in reset", step_out, 0);
        chk("R1 ovf_err in reset", ovf_err, 0);
        @(negedge clk);
        rst_n = 1;
        log_n = 0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 step_out after reset", step_out, 0);
        chk("R1 ovf_err after reset", ovf_err, 0);
    endtask

    task automatic t_first_and_boundary();
        int t0;
        gap_ext_en = 1; gap_cycles = 5;
        log_n = 0; t0 = cyc;
        drive(1, 1);              // t0
        idle(4);
        drive(1, 0);              // t0+5: on the boundary
        idle(3);
        drive(1, 1);              // t0+9: one cycle early
        idle(20);
        drive(1, 0);              // t0+30: wide spacing
        idle(3);
        chk("R2 count", log_n, 4);
        chk("R2 first passes", log_cyc[0] - t0, 1);
        chk("R3 boundary passes", log_cyc[1] - t0, 6);
        chk("R3 boundary dir", log_dir[1], 0);
        chk("R4 early delayed to gap", log_cyc[2] - t0, 11);
        chk("R3 wide passes", log_cyc[3] - t0, 31);
    endtask

    task automatic t_burst_order();
        int t0;
        gap_ext_en = 1; gap_cycles = 5;
        idle(10);
        log_n = 0; t0 = cyc;
        drive(1, 1); drive(1, 0); drive(1, 1);
        idle(20);
        chk("R5 count, no cancel", log_n, 3);
        chk("R4 second at gap", log_cyc[1] - t0, 6);
        chk("R4 third at gap", log_cyc[2] - t0, 11);
        chk("R5 dir order 0", log_dir[0], 1);
        chk("R5 dir order 1", log_dir[1], 0);
        chk("R5 dir order 2", log_dir[2], 1);
    endtask

    task automatic t_every_clock(int g);
        int t0;
        gap_ext_en = 1; gap_cycles = 10'(g);
        idle(5);
        log_n = 0; t0 = cyc;
        drive(1, 0); drive(1, 1); drive(1, 0); drive(1, 1);
        idle(3);
        chk("R6 count", log_n, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R6 every clock", log_cyc[i] - t0, i + 1);
            chk("R6 dir", log_dir[i], i % 2);
        end
    endtask

    task automatic t_overflow();
        int t0;
        bit dirs [6] = '{1, 0, 0, 1, 1, 0};
        gap_ext_en = 1; gap_cycles = 20;
        idle(30);
        log_n = 0; t0 = cyc;
        for (int i = 0; i < 6; i++) drive(1, dirs[i]);
        idle(110);
        chk("R7 newest dropped", log_n, 5);
        for (int i = 0; i < 5; i++) begin
            chk("R7 spacing", log_cyc[i] - t0, 1 + 20 * i);
            chk("R7 dir", log_dir[i], dirs[i]);
        end
        chk("R7 err set", ovf_err, 1);
        idle(20);
        chk("R7 err sticky", ovf_err, 1);
        do_reset();
        chk("R7 err cleared by reset", ovf_err, 0);
    endtask

    task automatic t_default_gap();
        int t0;
        gap_ext_en = 0; gap_cycles = 50;
        idle(10);
        log_n = 0; t0 = cyc;
        drive(1, 1); drive(1, 0);
        idle(10);
        chk("R8 count", log_n, 2);
        chk("R8 default gap used", log_cyc[1] - t0, 5);
        gap_ext_en = 1;
    endtask

    task automatic t_reset_flush();
        int t1;
        gap_ext_en = 1; gap_cycles = 30;
        idle(40);
        drive(1, 1); drive(1, 0); drive(1, 1);
        idle(2);
        do_reset();
        t1 = cyc;
        drive(1, 0);
        idle(80);
        chk("R2 passes after reset", log_cyc[0] - t1, 1);
        chk("R9 queued events discarded", log_n, 1);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset_state();
        t_first_and_boundary();
        t_burst_order();
        t_every_clock(0);
        t_every_clock(1);
        t_overflow();
        t_default_gap();
        t_reset_flush();
        done = 1;
    end

    initial begin
        while (!done && cyc < 20000) @(negedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule